// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six live condition and mode flags of an 8-bit processor and rewrites them once per retired instruction. The decoder hands it a small operation-class code. The arithmetic unit hands it candidate negative, overflow, zero and carry values. The stack path hands it a pulled byte. The class code picks which flags may change and where each new value comes from. Flags outside the class's write set keep their value. Some classes force a constant: a logical right shift always clears negative, break and interrupt entry set interrupt-disable, and the explicit set/clear classes force one flag each.

The block also returns two byte views of the held flags. One is a status view for reading. The other is a push view for saving to the stack, whose break bit tells a software break or status push from a hardware interrupt. A branch-condition select picks one of the four testable flags and the value it must have, and the block reports whether the branch is taken. All state changes happen on a rising clock edge while the update strobe is high. Reset is asynchronous and active low, and its release passes through a two-stage synchronizer.

Top module: `psw_status_reg`

## Requirements
- R1: Reset is asynchronous and active low. Its release is synchronized to the clock. Out of reset, interrupt-disable is 1 and every other stored flag is 0, so the status view reads 0x24 and the push view reads 0x34 for any class other than hardware interrupt.
- R2: Both byte views place negative at bit 7, overflow at bit 6, decimal at bit 3, interrupt-disable at bit 2, zero at bit 1 and carry at bit 0. Bit 5 always reads 1. In the status view bit 4 always reads 0.
- R3: While the update strobe is low, no stored flag changes, whatever the other inputs are.
- R4: Class 1 (loads, transfers other than to the stack pointer, increments, decrements, AND/OR/XOR, pull accumulator) copies the candidate negative and zero and keeps the other flags.
- R5: Class 2 (shifts left, rotates, compares) copies candidate negative, zero and carry. Class 4 (add/subtract with carry) copies candidate negative, overflow, zero and carry.
- R6: Class 3 (logical shift right) clears negative and copies candidate zero and carry, whatever the candidate negative is.
- R7: Class 5 (bit test) sets negative from operand bit 7 and overflow from operand bit 6. It sets zero when the accumulator AND operand is zero. Carry, decimal and interrupt-disable are kept.
- R8: Classes 6/7 clear/set carry, 8/9 clear/set decimal, 10/11 clear/set interrupt-disable, and 12 clears overflow. Each changes only its one flag.
- R9: Class 13 (pull status, return from interrupt) loads bits 7, 6, 3, 2, 1, 0 of the stack byte into negative, overflow, decimal, interrupt-disable, zero and carry. Stack byte bits 5 and 4 have no effect.
- R10: Class 14 (software break) and class 15 (hardware interrupt) set interrupt-disable and keep the other flags. Class 0 (stores, pushes, jumps, call, return, no-op) and class codes 16 to 31 change nothing.
- R11: The push view's bit 4 reads 0 while the applied class is 15 and reads 1 otherwise.
- R12: The branch select bits [2:1] pick the flag: 00 negative, 01 overflow, 10 carry, 11 zero. Select bit 0 is the value required. The branch-taken output is 1 exactly when the picked flag equals that value. It is combinational from the held flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Update strobe; flags change only while high |
| op_class | input | 5 | Operation class code (0 to 15 defined) |
| alu_n | input | 1 | Candidate negative from the arithmetic unit |
| alu_v | input | 1 | Candidate overflow from the arithmetic unit |
| alu_z | input | 1 | Candidate zero from the arithmetic unit |
| alu_c | input | 1 | Candidate carry from the arithmetic unit |
| acc_val | input | 8 | Accumulator value for the bit-test class |
| opnd_val | input | 8 | Memory operand for the bit-test class |
| stack_byte | input | 8 | Byte pulled from the stack for the restore class |
| br_sel | input | 3 | Branch condition select |
| status_o | output | 8 | Status view of the held flags |
| push_o | output | 8 | Push view with the break bit formatted |
| br_taken | output | 1 | Selected branch condition is met |

## Verification
The assertions check these rules on every cycle: flags stay put while the strobe is low, a logical right shift leaves negative clear, break and interrupt entry leave interrupt-disable set, a set/clear class changes at most one flag, and a restore loads exactly the relevant stack-byte bits. A behavioural model in the bench checks the rest: which candidate each class copies, the bit-test zero computed from the accumulator AND operand, the push-view break bit for the hardware-interrupt case, the eight branch conditions, and that undefined class codes and stack bits 5 and 4 have no effect. These can only be seen by comparing outputs with an independent model over many directed and random cycles.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int unsigned STATUS_W = 8;
  localparam int unsigned CLASS_W  = 5;
  localparam int unsigned BSEL_W   = 3;

  // bit positions inside the byte views
  localparam int unsigned BIT_N = 7;
  localparam int unsigned BIT_V = 6;
  localparam int unsigned BIT_1 = 5;
  localparam int unsigned BIT_B = 4;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned BIT_I = 2;
  localparam int unsigned BIT_Z = 1;
  localparam int unsigned BIT_C = 0;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } psw_flags_t;

  typedef enum logic [CLASS_W-1:0] {
    CLS_KEEP    = 5'd0,
    CLS_NZ      = 5'd1,
    CLS_NZC     = 5'd2,
    CLS_SHR     = 5'd3,
    CLS_NVZC    = 5'd4,
    CLS_BITTEST = 5'd5,
    CLS_CLR_C   = 5'd6,
    CLS_SET_C   = 5'd7,
    CLS_CLR_D   = 5'd8,
    CLS_SET_D   = 5'd9,
    CLS_CLR_I   = 5'd10,
    CLS_SET_I   = 5'd11,
    CLS_CLR_V   = 5'd12,
    CLS_RESTORE = 5'd13,
    CLS_SWBRK   = 5'd14,
    CLS_HWIRQ   = 5'd15
  } op_class_e;

  localparam psw_flags_t FLAGS_RST = '{n:1'b0, v:1'b0, d:1'b0, i:1'b1, z:1'b0, c:1'b0};

  function automatic logic [STATUS_W-1:0] pack_view(input psw_flags_t f, input logic b);
    logic [STATUS_W-1:0] r;
    r        = '0;
    r[BIT_N] = f.n;
    r[BIT_V] = f.v;
    r[BIT_1] = 1'b1;
    r[BIT_B] = b;
    r[BIT_D] = f.d;
    r[BIT_I] = f.i;
    r[BIT_Z] = f.z;
    r[BIT_C] = f.c;
    return r;
  endfunction

endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/psw_update_decode.sv
module psw_update_decode
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [CLASS_W-1:0] op_class,
  input  logic               alu_n,
  input  logic               alu_v,
  input  logic               alu_z,
  input  logic               alu_c,
  input  logic [DATA_W-1:0]  acc_val,
  input  logic [DATA_W-1:0]  opnd_val,
  input  logic [DATA_W-1:0]  stack_byte,
  output psw_flags_t         wr_mask,
  output psw_flags_t         wr_val
);

  localparam int unsigned MSB = DATA_W - 1;

  logic bit_zero;

  always_comb begin
    bit_zero = ~|(acc_val & opnd_val);
  end

  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    case (op_class)
      CLS_NZ: begin
        wr_mask.n = 1'b1; wr_val.n = alu_n;
        wr_mask.z = 1'b1; wr_val.z = alu_z;
      end
      CLS_NZC: begin
        wr_mask.n = 1'b1; wr_val.n = alu_n;
        wr_mask.z = 1'b1; wr_val.z = alu_z;
        wr_mask.c = 1'b1; wr_val.c = alu_c;
      end
      CLS_SHR: begin
        wr_mask.n = 1'b1; wr_val.n = 1'b0;
        wr_mask.z = 1'b1; wr_val.z = alu_z;
        wr_mask.c = 1'b1; wr_val.c = alu_c;
      end
      CLS_NVZC: begin
        wr_mask.n = 1'b1; wr_val.n = alu_n;
        wr_mask.v = 1'b1; wr_val.v = alu_v;
        wr_mask.z = 1'b1; wr_val.z = alu_z;
        wr_mask.c = 1'b1; wr_val.c = alu_c;
      end
      CLS_BITTEST: begin
        wr_mask.n = 1'b1; wr_val.n = opnd_val[MSB];
        wr_mask.v = 1'b1; wr_val.v = opnd_val[MSB-1];
        wr_mask.z = 1'b1; wr_val.z = bit_zero;
      end
      CLS_CLR_C: begin wr_mask.c = 1'b1; wr_val.c = 1'b0; end
      CLS_SET_C: begin wr_mask.c = 1'b1; wr_val.c = 1'b1; end
      CLS_CLR_D: begin wr_mask.d = 1'b1; wr_val.d = 1'b0; end
      CLS_SET_D: begin wr_mask.d = 1'b1; wr_val.d = 1'b1; end
      CLS_CLR_I: begin wr_mask.i = 1'b1; wr_val.i = 1'b0; end
      CLS_SET_I: begin wr_mask.i = 1'b1; wr_val.i = 1'b1; end
      CLS_CLR_V: begin wr_mask.v = 1'b1; wr_val.v = 1'b0; end
      CLS_RESTORE: begin
        wr_mask  = '1;
        wr_val.n = stack_byte[BIT_N];
        wr_val.v = stack_byte[BIT_V];
        wr_val.d = stack_byte[BIT_D];
        wr_val.i = stack_byte[BIT_I];
        wr_val.z = stack_byte[BIT_Z];
        wr_val.c = stack_byte[BIT_C];
      end
      CLS_SWBRK, CLS_HWIRQ: begin
        wr_mask.i = 1'b1; wr_val.i = 1'b1;
      end
      default: begin
        wr_mask = '0;
        wr_val  = '0;
      end
    endcase
  end

endmodule

// File: rtl/psw_branch_eval.sv
module psw_branch_eval
  import psw_pkg::*;
(
  input  psw_flags_t         flags,
  input  logic [BSEL_W-1:0]  br_sel,
  output logic               br_taken
);

  logic picked;

  always_comb begin
    case (br_sel[BSEL_W-1:1])
      2'b00:   picked = flags.n;
      2'b01:   picked = flags.v;
      2'b10:   picked = flags.c;
      default: picked = flags.z;
    endcase
    br_taken = (picked == br_sel[0]);
  end

endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [CLASS_W-1:0]  op_class,
  input  logic                alu_n,
  input  logic                alu_v,
  input  logic                alu_z,
  input  logic                alu_c,
  input  logic [DATA_W-1:0]   acc_val,
  input  logic [DATA_W-1:0]   opnd_val,
  input  logic [DATA_W-1:0]   stack_byte,
  input  logic [BSEL_W-1:0]   br_sel,
  output logic [STATUS_W-1:0] status_o,
  output logic [STATUS_W-1:0] push_o,
  output logic                br_taken
);

  logic       rst_sync_n;
  psw_flags_t flags_q;
  psw_flags_t flags_d;
  psw_flags_t wr_mask;
  psw_flags_t wr_val;
  logic       hw_entry;

  psw_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psw_update_decode #(.DATA_W(DATA_W)) u_decode (
    .op_class   (op_class),
    .alu_n      (alu_n),
    .alu_v      (alu_v),
    .alu_z      (alu_z),
    .alu_c      (alu_c),
    .acc_val    (acc_val),
    .opnd_val   (opnd_val),
    .stack_byte (stack_byte),
    .wr_mask    (wr_mask),
    .wr_val     (wr_val)
  );

  psw_branch_eval u_branch (
    .flags    (flags_q),
    .br_sel   (br_sel),
    .br_taken (br_taken)
  );

  // next-state: masked merge, gated by the update strobe
  always_comb begin
    flags_d = flags_q;
    if (upd_en) begin
      flags_d = (flags_q & ~wr_mask) | (wr_val & wr_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= FLAGS_RST;
    else             flags_q <= flags_d;
  end

  always_comb begin
    hw_entry = (op_class == CLS_HWIRQ);
    status_o = pack_view(flags_q, 1'b0);
    push_o   = pack_view(flags_q, ~hw_entry);
  end

  // R3: strobe low freezes all flags
  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !upd_en |=> $stable(status_o));

  // R6: logical shift right leaves negative clear
  a_r6_shr_clears_neg: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && op_class == CLS_SHR) |=> !status_o[BIT_N]);

  // R8: explicit set/clear touches at most one flag
  a_r8_single_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && op_class >= CLS_CLR_C && op_class <= CLS_CLR_V)
      |=> ($countones(status_o ^ $past(status_o)) <= 1));

  // R9: restore loads the six live bits from the pulled byte
  a_r9_restore_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && op_class == CLS_RESTORE)
      |=> (status_o[7:6] == $past(stack_byte[7:6]) && status_o[3:0] == $past(stack_byte[3:0])));

  // R10: break and interrupt entry leave interrupt-disable set
  a_r10_entry_sets_i: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && (op_class == CLS_SWBRK || op_class == CLS_HWIRQ)) |=> status_o[BIT_I]);

endmodule

// File: tb/psw_status_reg_tb.sv
`timescale 1ns/1ps
module psw_status_reg_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       upd_en;
  logic [4:0] op_class;
  logic       alu_n, alu_v, alu_z, alu_c;
  logic [7:0] acc_val, opnd_val, stack_byte;
  logic [2:0] br_sel;
  logic [7:0] status_o, push_o;
  logic       br_taken;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference flags
  bit mn, mv, md, mi, mz, mc;

  always #4 clk = ~clk;

  psw_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .alu_n(alu_n), .alu_v(alu_v), .alu_z(alu_z), .alu_c(alu_c),
    .acc_val(acc_val), .opnd_val(opnd_val), .stack_byte(stack_byte),
    .br_sel(br_sel), .status_o(status_o), .push_o(push_o), .br_taken(br_taken)
  );

  function automatic logic [7:0] exp_status();
    return {mn, mv, 1'b1, 1'b0, md, mi, mz, mc};
  endfunction

  function automatic logic [7:0] exp_push();
    return {mn, mv, 1'b1, (op_class == 5'd15) ? 1'b0 : 1'b1, md, mi, mz, mc};
  endfunction

  function automatic logic exp_branch();
    bit f;
    case (br_sel[2:1])
      2'd0: f = mn;
      2'd1: f = mv;
      2'd2: f = mc;
      default: f = mz;
    endcase
    return f == br_sel[0];
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    if (!upd_en) return;
    case (op_class)
      5'd1:  begin mn = alu_n; mz = alu_z; end
      5'd2:  begin mn = alu_n; mz = alu_z; mc = alu_c; end
      5'd3:  begin mn = 0; mz = alu_z; mc = alu_c; end
      5'd4:  begin mn = alu_n; mv = alu_v; mz = alu_z; mc = alu_c; end
      5'd5:  begin mn = opnd_val[7]; mv = opnd_val[6]; mz = ((acc_val & opnd_val) == 0); end
      5'd6:  mc = 0;
      5'd7:  mc = 1;
      5'd8:  md = 0;
      5'd9:  md = 1;
      5'd10: mi = 0;
      5'd11: mi = 1;
      5'd12: mv = 0;
      5'd13: begin
        mn = stack_byte[7]; mv = stack_byte[6]; md = stack_byte[3];
        mi = stack_byte[2]; mz = stack_byte[1]; mc = stack_byte[0];
      end
      5'd14, 5'd15: mi = 1;
      default: ;
    endcase
  endtask

  // one cycle: drive at falling edge, compare, then advance the model at the rising edge
  task automatic step(string tag, bit en, int op, bit an, bit av, bit az, bit ac,
                      logic [7:0] acc, logic [7:0] opd, logic [7:0] stk, logic [2:0] bs);
    @(negedge clk);
    upd_en = en; op_class = op[4:0];
    alu_n = an; alu_v = av; alu_z = az; alu_c = ac;
    acc_val = acc; opnd_val = opd; stack_byte = stk; br_sel = bs;
    #1;
    check8(tag, status_o, exp_status(), "status");
    check8(tag, push_o, exp_push(), "push");
    check8("R12", {7'd0, br_taken}, {7'd0, exp_branch()}, "branch");
    @(posedge clk);
    model_update();
  endtask

  task automatic rnd_step(string tag, bit en, int op);
    step(tag, en, op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom));
  endtask

  initial begin
    rst_n = 0; upd_en = 0; op_class = 0;
    alu_n = 0; alu_v = 0; alu_z = 0; alu_c = 0;
    acc_val = 0; opnd_val = 0; stack_byte = 0; br_sel = 0;
    mn = 0; mv = 0; md = 0; mi = 1; mz = 0; mc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 / R2: reset views
    @(negedge clk); #1;
    check8("R1", status_o, 8'h24, "reset status");
    check8("R1", push_o, 8'h34, "reset push");

    // R3: strobe low, every class with random data
    for (int k = 0; k < 64; k++) rnd_step("R3", 0, k % 32);

    // R4 / R5 / R6
    step("R4", 1, 1, 1, 1, 1, 1, 0, 0, 0, 0);
    step("R4", 1, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R5", 1, 2, 1, 0, 0, 1, 0, 0, 0, 4);
    step("R5", 1, 4, 0, 1, 1, 0, 0, 0, 0, 2);
    step("R5", 1, 4, 1, 0, 0, 1, 0, 0, 0, 7);
    step("R6", 1, 3, 1, 1, 0, 1, 0, 0, 0, 0);
    step("R6", 1, 3, 1, 1, 1, 0, 0, 0, 0, 1);

    // R7: bit test, zero from accumulator AND operand
    step("R7", 1, 5, 0, 0, 0, 0, 8'h0F, 8'hC0, 0, 3);
    step("R7", 1, 5, 1, 1, 0, 0, 8'h41, 8'h41, 0, 6);
    step("R7", 1, 5, 0, 0, 1, 0, 8'hFF, 8'h00, 0, 5);

    // R8: each single-flag class, twice to see both directions
    for (int k = 6; k <= 12; k++) step("R8", 1, k, 1, 1, 1, 1, 0, 0, 0, 3'(k));
    for (int k = 12; k >= 6; k--) step("R8", 1, k, 0, 0, 0, 0, 0, 0, 0, 3'(k));

    // R9: restore, bits 5 and 4 of the pulled byte set and clear
    step("R9", 1, 13, 0, 0, 0, 0, 0, 0, 8'hFF, 0);
    step("R9", 1, 13, 0, 0, 0, 0, 0, 0, 8'h30, 1);
    step("R9", 1, 13, 0, 0, 0, 0, 0, 0, 8'hCB, 2);
    step("R9", 1, 13, 0, 0, 0, 0, 0, 0, 8'h14, 3);

    // R10: entries set I; keep class and undefined codes change nothing
    step("R10", 1, 10, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 14, 1, 1, 1, 1, 0, 0, 0, 0);
    step("R10", 1, 10, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 15, 1, 1, 1, 1, 0, 0, 0, 0);
    for (int k = 16; k < 32; k++) rnd_step("R10", 1, k);
    rnd_step("R10", 1, 0);

    // R11: push view break bit under each class
    for (int k = 0; k < 16; k++) rnd_step("R11", 0, k);

    // mixed random traffic
    for (int k = 0; k < 3000; k++) rnd_step("R5", 1'($urandom), int'($urandom % 32));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule